// File: doc/BRIEF.md
# Nibble-Wide Register Slave on a Serial Peripheral Link

This block is a serial slave that sits behind a four-wire SPI link and exposes a small bank of 4-bit registers to a host controller. Every transaction is one byte, sent most significant bit first. The upper half of the byte holds a register address and a direction flag. The lower half holds write data, or it is the window in which the slave returns read data. The host therefore sends the address and direction, and then reads the answer within the same byte. The slave decodes the request half-way through the frame and launches the read nibble before the fifth clock.

Each address has two meanings. A write updates a control nibble that the block holds and presents on `ctrl_o`. A read returns a status nibble taken from the `status_i` input port. The status nibble is captured once the direction bit has arrived. Writes take effect only when chip select is released after exactly eight clocks. Frames of any other length are dropped. The link runs in mode 0: the slave samples on the rising SCK edge and changes its output on the falling edge. SCK, chip select and MOSI are oversampled by the local clock through a synchronizer, so SCK must be much slower than `clk_i`.

Top module: `spi_nib_slave`

## Requirements
- R1: In a frame, bits 7..5 are the address A, bit 4 is the direction (1 = write, 0 = read), and bits 3..0 are data, sent MSB first. An 8-bit write frame sets `ctrl_o[4*A+3:4*A]` to the data.
- R2: A write changes `ctrl_o` only after chip select deasserts. While chip select stays low, `ctrl_o` holds its value.
- R3: A frame in which chip select is released after a number of SCK rising edges other than 8 changes no control nibble.
- R4: In a read frame, MISO is valid at the rising SCK edges of bits 3, 2, 1 and 0. At those edges it carries `status_i[4*A+3:4*A]` in that order, MSB first, and it changes only after falling edges.
- R5: The read nibble is captured after the direction bit is received. A later change on `status_i` in the same frame does not alter the bits shifted out.
- R6: A read frame leaves every control nibble unchanged.
- R7: MISO is low while chip select is inactive, during the first four bits of any frame, and throughout write frames.
- R8: While `rst_ni` is low, and just after it is released, every control nibble is zero and MISO is low.
- R9: A write to one address leaves the nibbles of all other addresses unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Local oversampling clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sck_i | input | 1 | Serial clock from the host, idle low |
| cs_ni | input | 1 | Active-low chip select |
| mosi_i | input | 1 | Serial data from the host |
| miso_o | output | 1 | Serial data to the host, held low when not reading |
| status_i | input | 32 | Eight status nibbles; nibble A is returned on a read of address A |
| ctrl_o | output | 32 | Eight control nibbles; nibble A is written by a write to address A |

## Verification
The assertions assume that `cs_ni` is held steady for at least three local clocks around each change, that each SCK level lasts longer than the synchronizer delay, and that SCK is low whenever chip select changes. Under these assumptions the port-level latency windows used in the properties hold. The bench drives every SCK and chip-select level for four local clocks and keeps SCK low at frame edges. It changes `status_i` only between frames, except in the one case that deliberately changes it after the direction bit to test the capture point.

// File: rtl/spi_nib_pkg.sv
package spi_nib_pkg;
  typedef enum logic {
    DIR_READ  = 1'b0,
    DIR_WRITE = 1'b1
  } dir_e;
endpackage

// File: rtl/spi_nib_sync.sv
module spi_nib_sync #(
  parameter int unsigned STAGES  = 2,
  parameter logic        RST_VAL = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o,
  output logic rise_o,
  output logic fall_o
);
  logic [STAGES-1:0] chain_q;
  logic              prev_q;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) chain_q[g] <= RST_VAL;
        else if (g == 0) chain_q[g] <= d_i;
        else chain_q[g] <= chain_q[(g == 0) ? 0 : g-1];
      end
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= RST_VAL;
    else prev_q <= chain_q[STAGES-1];
  end

  assign q_o    = chain_q[STAGES-1];
  assign rise_o = chain_q[STAGES-1] & ~prev_q;
  assign fall_o = ~chain_q[STAGES-1] & prev_q;
endmodule

// File: rtl/spi_nib_shift.sv
module spi_nib_shift
  import spi_nib_pkg::*;
#(
  parameter int unsigned ADDR_W = 3,
  parameter int unsigned DATA_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sck_rise_i,
  input  logic              sck_fall_i,
  input  logic              cs_act_i,
  input  logic              cs_end_i,
  input  logic              mosi_i,
  input  logic [DATA_W-1:0] rd_nib_i,
  output logic [ADDR_W-1:0] peek_addr_o,
  output logic              wr_en_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [DATA_W-1:0] wr_data_o,
  output logic              miso_o
);
  localparam int unsigned HDR_W   = ADDR_W + 1;
  localparam int unsigned FRAME_W = HDR_W + DATA_W;
  localparam int unsigned CNT_MAX = FRAME_W + 1;
  localparam int unsigned CNT_W   = $clog2(CNT_MAX + 1);

  logic [FRAME_W-1:0] sr_q;
  logic [CNT_W-1:0]   cnt_q;
  logic               rd_q;
  logic [DATA_W-1:0]  out_q;
  logic               miso_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q   <= '0;
      cnt_q  <= '0;
      rd_q   <= 1'b0;
      out_q  <= '0;
      miso_q <= 1'b0;
    end else if (!cs_act_i) begin
      cnt_q  <= '0;
      rd_q   <= 1'b0;
      miso_q <= 1'b0;
    end else if (sck_rise_i) begin
      sr_q <= {sr_q[FRAME_W-2:0], mosi_i};
      if (cnt_q != CNT_W'(CNT_MAX)) cnt_q <= cnt_q + 1'b1;
      // direction bit arrives now: capture status for the data half
      if (cnt_q == CNT_W'(HDR_W - 1) && mosi_i == DIR_READ) begin
        rd_q  <= 1'b1;
        out_q <= rd_nib_i;
      end
    end else if (sck_fall_i && rd_q &&
                 cnt_q >= CNT_W'(HDR_W) && cnt_q < CNT_W'(FRAME_W)) begin
      miso_q <= out_q[DATA_W-1];
      out_q  <= out_q << 1;
    end
  end

  assign peek_addr_o = sr_q[ADDR_W-1:0];
  assign wr_en_o     = cs_end_i && (cnt_q == CNT_W'(FRAME_W)) && (sr_q[DATA_W] == DIR_WRITE);
  assign wr_addr_o   = sr_q[FRAME_W-1 -: ADDR_W];
  assign wr_data_o   = sr_q[DATA_W-1:0];
  assign miso_o      = miso_q;
endmodule

// File: rtl/spi_nib_regs.sv
module spi_nib_regs #(
  parameter int unsigned ADDR_W = 3,
  parameter int unsigned DATA_W = 4
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          wr_en_i,
  input  logic [ADDR_W-1:0]             wr_addr_i,
  input  logic [DATA_W-1:0]             wr_data_i,
  input  logic [ADDR_W-1:0]             rd_addr_i,
  input  logic [(1<<ADDR_W)*DATA_W-1:0] status_i,
  output logic [DATA_W-1:0]             rd_nib_o,
  output logic [(1<<ADDR_W)*DATA_W-1:0] ctrl_o
);
  localparam int unsigned NREG = 1 << ADDR_W;

  genvar g;
  generate
    for (g = 0; g < NREG; g++) begin : g_reg
      logic [DATA_W-1:0] nib_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) nib_q <= '0;
        else if (wr_en_i && wr_addr_i == ADDR_W'(g)) nib_q <= wr_data_i;
      end
      assign ctrl_o[g*DATA_W +: DATA_W] = nib_q;
    end
  endgenerate

  assign rd_nib_o = status_i[rd_addr_i*DATA_W +: DATA_W];
endmodule

// File: rtl/spi_nib_slave.sv
module spi_nib_slave #(
  parameter int unsigned ADDR_W      = 3,
  parameter int unsigned DATA_W      = 4,
  parameter int unsigned SYNC_STAGES = 2,
  localparam int unsigned NREG       = 1 << ADDR_W
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   sck_i,
  input  logic                   cs_ni,
  input  logic                   mosi_i,
  output logic                   miso_o,
  input  logic [NREG*DATA_W-1:0] status_i,
  output logic [NREG*DATA_W-1:0] ctrl_o
);
  logic sck_s, sck_rise, sck_fall;
  logic cs_s, cs_end, cs_start;
  logic mosi_s, mosi_r, mosi_f;
  logic [ADDR_W-1:0] peek_addr, wr_addr;
  logic [DATA_W-1:0] rd_nib, wr_data;
  logic              wr_en;

  spi_nib_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_sck (
    .clk_i, .rst_ni, .d_i(sck_i), .q_o(sck_s), .rise_o(sck_rise), .fall_o(sck_fall));
  spi_nib_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_cs (
    .clk_i, .rst_ni, .d_i(cs_ni), .q_o(cs_s), .rise_o(cs_end), .fall_o(cs_start));
  spi_nib_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_mosi (
    .clk_i, .rst_ni, .d_i(mosi_i), .q_o(mosi_s), .rise_o(mosi_r), .fall_o(mosi_f));

  spi_nib_shift #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_shift (
    .clk_i, .rst_ni,
    .sck_rise_i(sck_rise), .sck_fall_i(sck_fall),
    .cs_act_i(~cs_s), .cs_end_i(cs_end), .mosi_i(mosi_s),
    .rd_nib_i(rd_nib), .peek_addr_o(peek_addr),
    .wr_en_o(wr_en), .wr_addr_o(wr_addr), .wr_data_o(wr_data),
    .miso_o(miso_o));

  spi_nib_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
    .clk_i, .rst_ni,
    .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .rd_addr_i(peek_addr), .status_i(status_i),
    .rd_nib_o(rd_nib), .ctrl_o(ctrl_o));

  logic unused_edges;
  assign unused_edges = sck_s ^ cs_start ^ mosi_r ^ mosi_f;
endmodule

// File: rtl/spi_nib_chk.sv
module spi_nib_chk #(
  parameter int unsigned NREG   = 8,
  parameter int unsigned DATA_W = 4
) (
  input logic                   clk_i,
  input logic                   rst_ni,
  input logic                   cs_ni,
  input logic                   miso_o,
  input logic [NREG*DATA_W-1:0] ctrl_o
);
  logic [NREG*DATA_W-1:0] prev_q;
  logic [NREG-1:0]        nib_diff;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= '0;
    else prev_q <= ctrl_o;
  end

  genvar g;
  generate
    for (g = 0; g < NREG; g++) begin : g_diff
      assign nib_diff[g] = prev_q[g*DATA_W +: DATA_W] != ctrl_o[g*DATA_W +: DATA_W];
    end
  endgenerate

  AST_RESET_CTRL_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(rst_ni) |-> (ctrl_o == '0 && !miso_o)); // R8

  AST_CTRL_HOLD_IN_FRAME: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(ctrl_o) |-> $past(cs_ni, 3)); // R2

  AST_ONE_NIBBLE_PER_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(nib_diff)); // R9

  AST_IDLE_MISO_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_ni && $past(cs_ni, 1) && $past(cs_ni, 2) && $past(cs_ni, 3)) |-> !miso_o); // R7
endmodule

bind spi_nib_slave spi_nib_chk #(.NREG(NREG), .DATA_W(DATA_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .cs_ni(cs_ni), .miso_o(miso_o), .ctrl_o(ctrl_o));

// File: tb/spi_nib_slave_tb.sv
module spi_nib_slave_tb;
  localparam int CLK_PERIOD = 10;
  localparam int HOLD = 4;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        sck = 1'b0, cs_n = 1'b1, mosi = 1'b0;
  logic        miso;
  logic [31:0] status = '0;
  logic [31:0] ctrl;
  logic [31:0] exp_ctrl = '0;
  bit          mon_en = 1'b0;
  int          total = 0, bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_nib_slave u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .sck_i(sck), .cs_ni(cs_n), .mosi_i(mosi),
    .miso_o(miso), .status_i(status), .ctrl_o(ctrl));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // per-clock compare of control nibbles against the model
  always @(negedge clk) if (mon_en) chk("R1/R2/R3/R6/R9 ctrl", ctrl, exp_ctrl);

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic frame(input logic [15:0] bits, input int n, input logic [3:0] nib,
                       input bit mutate);
    logic [2:0] a;
    bit         is_rd;
    bit         commit;
    is_rd  = (n == 8) && !bits[4];
    commit = (n == 8) && bits[4];
    a      = bits[7:5];
    cs_n = 1'b0;
    wait_n(HOLD);
    for (int i = 0; i < n; i++) begin
      mosi = bits[n-1-i];
      wait_n(HOLD);
      if (is_rd && i >= 4) chk("R4 read bit", {31'b0, miso}, {31'b0, nib[7-i]});
      else chk("R7 miso low", {31'b0, miso}, 32'b0);
      sck = 1'b1;
      wait_n(HOLD);
      if (mutate && i == 3) status = ~status; // R5: after direction bit
      sck = 1'b0;
    end
    wait_n(HOLD);
    cs_n = 1'b1;
    repeat (3) @(posedge clk);
    if (commit) exp_ctrl[a*4 +: 4] = bits[3:0];
    @(negedge clk);
    chk("R7 idle miso", {31'b0, miso}, 32'b0);
    wait_n(HOLD);
  endtask

  initial begin
    #(CLK_PERIOD*150000);
    bad++;
    total++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    wait_n(5);
    chk("R8 reset ctrl", ctrl, 32'h0);
    chk("R8 reset miso", {31'b0, miso}, 32'b0);
    rst_ni = 1'b1;
    @(negedge clk);
    chk("R8 post reset", ctrl, 32'h0);
    mon_en = 1'b1;
    wait_n(4);

    // R1 / R9: write each address with its own value
    for (int a = 0; a < 8; a++) begin
      logic [3:0] d;
      d = 4'(a * 3 + 5);
      frame({8'b0, 3'(a), 1'b1, d}, 8, 4'h0, 1'b0);
    end

    // R4 / R6: read each address with a varied status pattern
    status = 32'hC3A5_9E17;
    for (int a = 0; a < 8; a++) begin
      frame({8'b0, 3'(a), 1'b0, 4'h0}, 8, status[a*4 +: 4], 1'b0);
    end
    status = 32'h5A0F_F0A5;
    frame({8'b0, 3'd6, 1'b0, 4'hF}, 8, status[27:24], 1'b0);

    // R5: status flips after the direction bit, read keeps the captured value
    status = 32'h1234_5678;
    frame({8'b0, 3'd2, 1'b0, 4'h0}, 8, 4'h6, 1'b1);

    // R3: short and long write frames are dropped
    frame({9'b0, 3'd1, 1'b1, 3'b111}, 7, 4'h0, 1'b0);
    frame({7'b0, 3'd4, 1'b1, 4'hA, 1'b1}, 9, 4'h0, 1'b0);
    frame({12'b0, 3'd0, 1'b1}, 4, 4'h0, 1'b0);

    // R1 / R2: overwrite after rejected frames, boundary addresses
    frame({8'b0, 3'd0, 1'b1, 4'hF}, 8, 4'h0, 1'b0);
    frame({8'b0, 3'd7, 1'b1, 4'h0}, 8, 4'h0, 1'b0);
    frame({8'b0, 3'd7, 1'b1, 4'h9}, 8, 4'h0, 1'b0);

    chk("R9 final map", ctrl, exp_ctrl);
    mon_en = 1'b0;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule